// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit count register with a 16-bit reload/capture register beside it. One counter serves five operating variants. In the plain reload variant the counter counts up and restarts from the stored value. In the capture variant a falling edge on a trigger pin latches the live count. The up/down variant takes its direction from the trigger pin level. The baud variant produces a one-cycle pulse for a serial port on every wrap. In the clock-out variant every wrap toggles a square-wave output that drives the count pin.

The block counts either the machine-cycle tick that the rest of the chip supplies or falling edges seen on the external count pin. That pin is sampled once per tick, after a parameterised synchroniser. A byte-wide register port writes and reads the control, mode, counter and capture registers. The overflow and external flags sit in the control register. The interrupt request combines the two flags.

Top module: `mmt_timer`

## Requirements
- R1: After reset every register reads 0, and irq_o, clkout_o, clkout_oe_o and baud_tick_o are 0. Register addresses: 0 control, 1 mode, 2 counter low byte, 3 counter high byte, 4 capture low byte, 5 capture high byte.
- R2: Control bit 0 (run) enables counting. With control bit 1 (source) clear, the counter advances by one on each cycle where tick_i is high. With run clear, the counter holds.
- R3: With control bit 1 set, the counter advances once for each tick at which the synchronised count pin reads 0 after it read 1 at the previous tick.
- R4: In reload mode (control bits 2, 4 and 5 clear, mode bits 0 and 1 clear), a step from 0xFFFF loads the capture value and sets the overflow flag (control bit 6).
- R5: In capture mode (control bit 2 set), a step from 0xFFFF wraps to 0 and sets the overflow flag. If control bit 3 (trigger enable) is set, a tick at which the trigger pin falls from 1 to 0 copies the counter into the capture register and sets the external flag (control bit 7). If control bit 3 is clear, the falling edge leaves the capture register and the external flag unchanged.
- R6: In reload mode with control bit 3 set, a falling edge on the trigger pin loads the capture value into the counter and sets the external flag.
- R7: With mode bit 0 set (up/down mode), a trigger pin level of 1 counts up and a level of 0 counts down. Counting up from 0xFFFF loads the capture value. A down step taken when the counter equals the capture value loads 0xFFFF. Both of these wraps set the overflow flag.
- R8: In up/down mode each wrap toggles the external flag, and the external flag does not drive irq_o.
- R9: Setting control bit 4 or control bit 5 selects baud mode. Each wrap then reloads the capture value, gives one pulse on baud_tick_o, and leaves the overflow flag unchanged.
- R10: With mode bit 1 set (clock-out mode), clkout_oe_o is 1. Each wrap toggles clkout_o and reloads the capture value, and the overflow flag is not set.
- R11: irq_o is the overflow flag ORed with the external flag, except where R8 applies. A write to the control register writes both flags directly from data bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle enable |
| cnt_pin_i | input | 1 | External count pin |
| trg_pin_i | input | 1 | External trigger / direction pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| clkout_o | output | 1 | Clock-out drive for the count pin |
| clkout_oe_o | output | 1 | Output enable for the count pin |
| baud_tick_o | output | 1 | Baud-rate pulse for the serial port |

## Verification
The bench uses the defaults: an 8-bit register port, which makes a 16-bit counter, and a two-stage pin synchroniser. With these values the counter can be preloaded within two counts of 0xFFFF or of the capture value. Every wrap case, in every variant, therefore happens within a few ticks. The two synchroniser stages set how long the bench holds each pin level before the tick that samples it.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

   typedef enum logic [2:0] {
      M_RELOAD  = 3'd0,
      M_UPDOWN  = 3'd1,
      M_CAPTURE = 3'd2,
      M_BAUD    = 3'd3,
      M_CLKOUT  = 3'd4
   } mmt_mode_e;

   localparam logic [2:0] A_CTL    = 3'd0;
   localparam logic [2:0] A_MODE   = 3'd1;
   localparam logic [2:0] A_CNT_LO = 3'd2;
   localparam logic [2:0] A_CNT_HI = 3'd3;
   localparam logic [2:0] A_CAP_LO = 3'd4;
   localparam logic [2:0] A_CAP_HI = 3'd5;

   localparam int B_RUN  = 0;
   localparam int B_SRC  = 1;
   localparam int B_CAPM = 2;
   localparam int B_TEN  = 3;
   localparam int B_RXC  = 4;
   localparam int B_TXC  = 5;
   localparam int B_OVF  = 6;
   localparam int B_EXT  = 7;

   localparam int B_UD   = 0;
   localparam int B_CKO  = 1;

endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES > 4) begin : g_bad
         $error("mmt_sync: STAGES must be 0 to 4");
      end
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sh_q <= '0;
            end else begin
               sh_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mmt_edge.sv
module mmt_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic lvl_i,
   output logic fall_o
);

   logic smp_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     smp_q <= 1'b0;
      else if (tick_i) smp_q <= lvl_i;
   end

   assign fall_o = tick_i & smp_q & ~lvl_i;

   // R3: a counted edge always follows a sample that read 1
   p_fall_prev_high_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !smp_q);

endmodule

// File: rtl/mmt_core.sv
module mmt_core
   import mmt_pkg::*;
#(
   parameter int DW = 8,
   localparam int CW = 2 * DW
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  mmt_mode_e     mode_i,
   input  logic          run_i,
   input  logic          dir_up_i,
   input  logic          step_i,
   input  logic          trg_fall_i,
   input  logic          trg_en_i,
   input  logic          wr_cnt_lo_i,
   input  logic          wr_cnt_hi_i,
   input  logic          wr_cap_lo_i,
   input  logic          wr_cap_hi_i,
   input  logic [DW-1:0] wdata_i,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cap_o,
   output logic          wrap_o,
   output logic          ovf_set_o,
   output logic          ext_set_o,
   output logic          ext_tog_o
);

   localparam logic [CW-1:0] ALL1 = '1;
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q, cnt_d, cap_q, cap_d;
   logic          at_top, at_cap, go_up, go_dn, ovf_evt, unf_evt, trg_act;
   logic          wr_cnt, wr_cap;

   assign at_top  = (cnt_q == ALL1);
   assign at_cap  = (cnt_q == cap_q);
   assign go_dn   = run_i & step_i & (mode_i == M_UPDOWN) & ~dir_up_i;
   assign go_up   = run_i & step_i & ~go_dn;
   assign ovf_evt = go_up & at_top;
   assign unf_evt = go_dn & at_cap;
   assign trg_act = trg_fall_i & trg_en_i;
   assign wr_cnt  = wr_cnt_lo_i | wr_cnt_hi_i;
   assign wr_cap  = wr_cap_lo_i | wr_cap_hi_i;

   always_comb begin
      cnt_d = cnt_q;
      if (go_up) begin
         if (at_top) cnt_d = (mode_i == M_CAPTURE) ? '0 : cap_q;
         else        cnt_d = cnt_q + ONE;
      end else if (go_dn) begin
         if (at_cap) cnt_d = ALL1;
         else        cnt_d = cnt_q - ONE;
      end
      if (trg_act && mode_i == M_RELOAD) cnt_d = cap_q;
      if (wr_cnt_lo_i) cnt_d[DW-1:0]  = wdata_i;
      if (wr_cnt_hi_i) cnt_d[CW-1:DW] = wdata_i;
   end

   always_comb begin
      cap_d = cap_q;
      if (trg_act && mode_i == M_CAPTURE) cap_d = cnt_q;
      if (wr_cap_lo_i) cap_d[DW-1:0]  = wdata_i;
      if (wr_cap_hi_i) cap_d[CW-1:DW] = wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         cap_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         cap_q <= cap_d;
      end
   end

   assign cnt_o     = cnt_q;
   assign cap_o     = cap_q;
   assign wrap_o    = ovf_evt | unf_evt;
   assign ovf_set_o = wrap_o & (mode_i == M_RELOAD || mode_i == M_UPDOWN ||
                                mode_i == M_CAPTURE);
   assign ext_set_o = trg_act & (mode_i == M_RELOAD || mode_i == M_CAPTURE ||
                                 mode_i == M_BAUD);
   assign ext_tog_o = wrap_o & (mode_i == M_UPDOWN);

   // R2: a stopped counter with no write and no trigger reload keeps its value
   p_stopped_hold_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !wr_cnt && !trg_act) |=> $stable(cnt_q));

   // R4: reload-mode overflow restarts from the capture value
   p_reload_top_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == M_RELOAD && run_i && step_i && at_top && !trg_act && !wr_cnt)
      |=> cnt_q == $past(cap_q));

   // R7: a down step at the capture value lands on all ones
   p_down_wrap_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go_dn && at_cap && !wr_cnt) |=> cnt_q == ALL1);

   // R5: an enabled trigger edge in capture mode latches the count
   p_capture_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == M_CAPTURE && trg_act && !wr_cap) |=> cap_q == $past(cnt_q));

endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
   import mmt_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          cnt_pin_i,
   input  logic          trg_pin_i,
   input  logic          wr_en_i,
   input  logic [2:0]    addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic          ovf_flag_o,
   output logic          ext_flag_o,
   output logic          irq_o,
   output logic          clkout_o,
   output logic          clkout_oe_o,
   output logic          baud_tick_o
);

   localparam int CW = 2 * DW;

   generate
      if (DW < 8) begin : g_dw_check
         $error("mmt_timer: DW must be at least 8");
      end
   endgenerate

   logic [5:0]    cfg_q;
   logic [1:0]    mode_q;
   logic          ovf_q, ext_q, clk_q, baud_q;
   logic          cnt_sync, trg_sync, cnt_fall, trg_fall, step;
   logic          wr_ctl, wr_mode;
   logic [CW-1:0] cnt, cap;
   logic          wrap, ovf_set, ext_set, ext_tog;
   mmt_mode_e     msel;

   assign wr_ctl  = wr_en_i & (addr_i == A_CTL);
   assign wr_mode = wr_en_i & (addr_i == A_MODE);

   mmt_sync #(.STAGES(SYNC_STAGES)) i_cnt_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnt_pin_i), .q_o(cnt_sync));
   mmt_sync #(.STAGES(SYNC_STAGES)) i_trg_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trg_pin_i), .q_o(trg_sync));

   mmt_edge i_cnt_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .lvl_i(cnt_sync),
      .fall_o(cnt_fall));
   mmt_edge i_trg_edge (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .lvl_i(trg_sync),
      .fall_o(trg_fall));

   always_comb begin
      if (cfg_q[B_RXC] || cfg_q[B_TXC]) msel = M_BAUD;
      else if (mode_q[B_CKO])           msel = M_CLKOUT;
      else if (cfg_q[B_CAPM])           msel = M_CAPTURE;
      else if (mode_q[B_UD])            msel = M_UPDOWN;
      else                              msel = M_RELOAD;
   end

   // external events only count where the pin is an input
   assign step = (cfg_q[B_SRC] && msel != M_BAUD && msel != M_CLKOUT) ? cnt_fall
                                                                      : tick_i;

   mmt_core #(.DW(DW)) i_core (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (msel),
      .run_i       (cfg_q[B_RUN]),
      .dir_up_i    (trg_sync),
      .step_i      (step),
      .trg_fall_i  (trg_fall),
      .trg_en_i    (cfg_q[B_TEN]),
      .wr_cnt_lo_i (wr_en_i & (addr_i == A_CNT_LO)),
      .wr_cnt_hi_i (wr_en_i & (addr_i == A_CNT_HI)),
      .wr_cap_lo_i (wr_en_i & (addr_i == A_CAP_LO)),
      .wr_cap_hi_i (wr_en_i & (addr_i == A_CAP_HI)),
      .wdata_i     (wdata_i),
      .cnt_o       (cnt),
      .cap_o       (cap),
      .wrap_o      (wrap),
      .ovf_set_o   (ovf_set),
      .ext_set_o   (ext_set),
      .ext_tog_o   (ext_tog)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= '0;
         mode_q <= '0;
         ovf_q  <= 1'b0;
         ext_q  <= 1'b0;
         clk_q  <= 1'b0;
         baud_q <= 1'b0;
      end else begin
         if (wr_ctl) begin
            cfg_q <= wdata_i[5:0];
            ovf_q <= wdata_i[B_OVF];
            ext_q <= wdata_i[B_EXT];
         end else begin
            if (ovf_set)      ovf_q <= 1'b1;
            if (ext_set)      ext_q <= 1'b1;
            else if (ext_tog) ext_q <= ~ext_q;
         end
         if (wr_mode) mode_q <= wdata_i[1:0];
         if (wrap && msel == M_CLKOUT) clk_q <= ~clk_q;
         baud_q <= wrap & (msel == M_BAUD);
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CTL:    rdata_o[7:0] = {ext_q, ovf_q, cfg_q};
         A_MODE:   rdata_o[1:0] = mode_q;
         A_CNT_LO: rdata_o = cnt[DW-1:0];
         A_CNT_HI: rdata_o = cnt[CW-1:DW];
         A_CAP_LO: rdata_o = cap[DW-1:0];
         A_CAP_HI: rdata_o = cap[CW-1:DW];
         default:  rdata_o = '0;
      endcase
   end

   assign ovf_flag_o  = ovf_q;
   assign ext_flag_o  = ext_q;
   assign irq_o       = ovf_q | (ext_q & (msel != M_UPDOWN));
   assign clkout_o    = clk_q;
   assign clkout_oe_o = mode_q[B_CKO];
   assign baud_tick_o = baud_q;

   // R9: baud mode never raises the overflow flag by itself
   p_baud_no_ovf_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msel == M_BAUD && !wr_ctl && !ovf_q) |=> !ovf_q);

   // R9: a baud pulse follows a wrap taken in baud mode
   p_baud_src_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      baud_tick_o |-> $past(msel == M_BAUD));

   // R10: each clock-out wrap flips the output
   p_clkout_flip_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msel == M_CLKOUT && wrap) |=> clkout_o != $past(clkout_o));

   // R11: a pending overflow always requests an interrupt
   p_irq_ovf_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_flag_o |-> irq_o);

endmodule

// File: tb/test_mmt_timer.sv
`timescale 1ns/1ps
module test_mmt_timer;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          cpin = 1'b0;
   logic          tpin = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    addr = 3'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          ovf_f, ext_f, irq, ck_o, ck_oe, baud;

   int total = 0;
   int bad   = 0;
   int baud_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) if (baud) baud_cnt++;

   mmt_timer #(.DW(DW), .SYNC_STAGES(2)) i_mmt_timer (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_pin_i(cpin),
      .trg_pin_i(tpin), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .ovf_flag_o(ovf_f), .ext_flag_o(ext_f), .irq_o(irq),
      .clkout_o(ck_o), .clkout_oe_o(ck_oe), .baud_tick_o(baud));

   // {ctl, mode, cnt, cap, trg, ticks, expected cnt, expected ctl read}
   localparam int NV = 7;
   localparam logic [87:0] VEC [NV] = '{
      88'h01_00_FFFD_1234_01_05_1236_41,   // R4 reload wrap
      88'h05_00_FFFE_0000_01_04_0002_45,   // R5 capture-mode wrap to 0
      88'h01_01_FFFF_0100_01_03_0102_C1,   // R7 up/down counting up
      88'h01_01_0102_0100_00_04_FFFE_C1,   // R7 up/down counting down
      88'h00_00_5555_0000_01_0A_5555_00,   // R2 stopped
      88'h11_00_FFFE_FFF0_01_03_FFF1_11,   // R9 baud reload, no flag
      88'h01_02_FFFF_FFFE_01_01_FFFE_01    // R10 clock-out reload, no flag
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rd16(input logic [2:0] a, output logic [15:0] d);
      logic [7:0] lo, hi;
      rd(a, lo);
      rd(a + 3'd1, hi);
      d = {hi, lo};
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] d);
      wr(a, d[7:0]);
      wr(a + 3'd1, d[15:8]);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), b);
         check($sformatf("R1 reg%0d", a), {24'd0, b}, 32'd0);
      end
      check("R1 irq", {31'd0, irq}, 0);
      check("R1 clkout", {30'd0, ck_oe, ck_o}, 0);
      check("R1 baud", {31'd0, baud}, 0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [87:0] v;
         v = VEC[i];
         wr(3'd0, 8'h00);
         wr(3'd1, v[79:72]);
         wr16(3'd2, v[71:56]);
         wr16(3'd4, v[55:40]);
         tpin = v[32];
         settle();
         ticks(2);
         wr(3'd0, v[87:80]);
         ticks(int'(v[31:24]));
         rd16(3'd2, w);
         check($sformatf("vec%0d cnt (R2 R4 R5 R7 R9 R10)", i), {16'd0, w}, {16'd0, v[23:8]});
         rd(3'd0, b);
         check($sformatf("vec%0d ctl flags (R4 R7 R8 R9 R10)", i), {24'd0, b}, {24'd0, v[7:0]});
         if (i == 5) check("R9 one baud pulse", baud_cnt, 1);
         if (i == 6) check("R10 clkout high, oe on", {30'd0, ck_oe, ck_o}, 32'd3);
      end

      // R10: cap=cnt=FFFF wraps every tick, three toggles from 1
      wr16(3'd4, 16'hFFFF);
      wr16(3'd2, 16'hFFFF);
      ticks(3);
      check("R10 clkout toggled", {31'd0, ck_o}, 0);

      // R8 / R11: external flag masked in up/down mode only
      wr(3'd1, 8'h01);
      wr(3'd0, 8'h80);
      check("R8 ext masked in up/down", {30'd0, ext_f, irq}, 32'd2);
      wr(3'd1, 8'h00);
      check("R11 ext drives irq", {31'd0, irq}, 1);
      wr(3'd0, 8'h40);
      check("R11 ovf written by software", {30'd0, ovf_f, irq}, 32'd3);

      // R9: baud pulses, one per two ticks
      wr(3'd0, 8'h00);
      wr16(3'd2, 16'hFFFE);
      wr16(3'd4, 16'hFFFE);
      wr(3'd0, 8'h21);
      baud_cnt = 0;
      ticks(10);
      @(negedge clk);
      check("R9 baud pulse count", baud_cnt, 5);
      rd(3'd0, b);
      check("R9 no ovf", {24'd0, b}, 32'h21);

      // R3: external pin edges
      wr(3'd0, 8'h00);
      wr16(3'd2, 16'h0000);
      cpin = 1'b0; settle(); ticks(1);
      wr(3'd0, 8'h03);
      cpin = 1'b1; settle(); ticks(1);
      cpin = 1'b0; settle(); ticks(2);
      cpin = 1'b1; settle(); ticks(2);
      cpin = 1'b0; settle(); ticks(1);
      rd16(3'd2, w);
      check("R3 pin falling edges", {16'd0, w}, 32'd2);

      // R5: capture on trigger edge
      wr(3'd0, 8'h00);
      wr16(3'd2, 16'h4321);
      wr16(3'd4, 16'h0000);
      tpin = 1'b1; settle(); ticks(2);
      wr(3'd0, 8'h0C);
      tpin = 1'b0; settle(); ticks(1);
      rd16(3'd4, w);
      check("R5 captured", {16'd0, w}, 32'h4321);
      rd(3'd0, b);
      check("R5 ext flag set", {24'd0, b}, 32'h8C);
      check("R5 irq", {31'd0, irq}, 1);

      // R5: trigger edge ignored without enable
      wr(3'd0, 8'h04);
      wr16(3'd2, 16'h1111);
      tpin = 1'b1; settle(); ticks(1);
      tpin = 1'b0; settle(); ticks(1);
      rd16(3'd4, w);
      check("R5 no capture when disabled", {16'd0, w}, 32'h4321);
      rd(3'd0, b);
      check("R5 no ext flag when disabled", {24'd0, b}, 32'h04);

      // R6: trigger reload in reload mode
      wr(3'd0, 8'h00);
      wr16(3'd2, 16'h0500);
      wr16(3'd4, 16'h0AAA);
      tpin = 1'b1; settle(); ticks(2);
      wr(3'd0, 8'h08);
      tpin = 1'b0; settle(); ticks(1);
      rd16(3'd2, w);
      check("R6 trigger reload", {16'd0, w}, 32'h0AAA);
      rd(3'd0, b);
      check("R6 ext flag", {24'd0, b}, 32'h88);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule